// File: doc/BRIEF.md
# Serial control register bank

This block is a write-only slave for a three-wire serial control link: a serial clock, a serial data line and an active-low frame enable. A host lowers the enable, shifts in a 13-bit word and raises the enable again. The word starts with a 3-bit register selector and ends with a 10-bit payload, and each part is sent most significant bit first. When the enable rises after a well-formed word, the payload is written into one of five control registers. The register contents drive parallel outputs that set the analog front end: an auxiliary DAC code, a pair of bandwidth codes, a gain code, a power and edge control word, and a clamp-level DAC code.

The three serial inputs are brought into the fabric clock domain through synchronizers and are oversampled there. The fabric clock must therefore run several times faster than the serial clock. A word of the wrong length is thrown away. A bandwidth write that sets either of its reserved bits is also thrown away, and it raises an error flag that stays set until reset. A gain request above the top of the usable range is clipped to that top value before it is stored.

Top module: `ser_ctl_bank`

## Requirements
- R1: A word is taken from `ser_dat` on each rising edge of `ser_clk` while `ser_en_n` is low. The first three bits form the selector (bit 2 first). The next ten bits form the payload (bit 9 first). Serial clock edges while `ser_en_n` is high have no effect.
- R2: Selector 0 stores payload bits 7..0 in `aux_code`. Payload bits 9..8 are ignored.
- R3: Selector 1 with payload bits 9..8 both zero stores payload bits 3..0 in `bw_fast` and payload bits 7..4 in `bw_slow`.
- R4: Selector 2 with a payload of 319 or less stores payload bits 8..0 in `gain_code` unchanged.
- R5: Selector 2 with a payload bits 8..0 value above 319 stores 319. `gain_code` never exceeds 319.
- R6: Selector 3 stores payload bits 6..0 in `pwr_ctl`.
- R7: Selector 4 stores all ten payload bits in `clamp_code`.
- R8: A word is committed only if exactly 13 serial clock rises were seen while the enable was low. Words of 12 or 14 bits leave every output unchanged.
- R9: Selector 1 with payload bit 9 or bit 8 set leaves `bw_fast` and `bw_slow` unchanged and sets `bw_err`. Once set, `bw_err` stays 1 until reset, including after later valid writes.
- R10: Selectors 5, 6 and 7 leave every output unchanged.
- R11: While `rst` is high at a rising `clk` edge, every output register returns to zero.
- R12: A committed write is visible on the outputs at most 6 `clk` cycles after the rising edge of `ser_en_n`. Outputs change only in response to a committed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; rising edge commits |
| aux_code | output | 8 | Auxiliary DAC code |
| bw_fast | output | 4 | Bandwidth code of the sampling stage |
| bw_slow | output | 4 | Bandwidth code of the gain stage |
| gain_code | output | 9 | Gain code, 0 to 319 |
| pwr_ctl | output | 7 | Partial power-down and edge-polarity bits |
| clamp_code | output | 10 | Clamp-level DAC code |
| bw_err | output | 1 | Sticky flag for a rejected bandwidth write |

## Verification
The assertions assume that the three serial inputs change slowly compared with `clk`. Each serial clock level and each data bit must last several fabric cycles. The data must be stable around every serial clock rise, and an enable edge must never arrive in the same fabric cycle as a serial clock rise. The stimulus meets these conditions in three ways. All inputs are driven on falling `clk` edges. Each serial clock phase is held for five fabric cycles, with the data bit set before the rise. The enable is moved only while the serial clock has been low for at least two cycles.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int SEL_W   = 3;
  localparam int WORD_W  = 10;
  localparam int FRAME_W = SEL_W + WORD_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_AUX   = 3'd0,
    SEL_BW    = 3'd1,
    SEL_GAIN  = 3'd2,
    SEL_PWR   = 3'd3,
    SEL_CLAMP = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[g]}};
      else     pipe <= {pipe[STAGES-2:0], d[g]};
    end
    assign q[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame #(
  parameter int SEL_W   = 3,
  parameter int WORD_W  = 10,
  localparam int FRAME_W = SEL_W + WORD_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              en_n_s,
  output logic              stb,
  output logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_d, en_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;
  logic               sclk_rise, en_fall, en_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_fall   = ~en_n_s & en_d;
  assign en_rise   = en_n_s & ~en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b1;
      cnt    <= '0;
      sr     <= '0;
      stb    <= 1'b0;
      sel    <= '0;
      word   <= '0;
    end else begin
      sclk_d <= sclk_s;
      en_d   <= en_n_s;
      stb    <= 1'b0;
      if (en_fall) begin
        cnt <= '0;
      end else if (!en_n_s && sclk_rise) begin
        sr <= {sr[FRAME_W-2:0], sdat_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      if (en_rise && cnt == CNT_FULL) begin
        stb  <= 1'b1;
        sel  <= sr[FRAME_W-1 -: SEL_W];
        word <= sr[WORD_W-1:0];
      end
    end
  end

  // R1: with the enable idle high, serial clock activity must not move the shifter
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (en_n_s && en_d) |=> ($stable(cnt) && $stable(sr)));

  // R8: a commit pulse only follows a word of exactly FRAME_W bits
  p_len_only_r8: assert property (@(posedge clk) disable iff (rst)
    stb |-> ($past(cnt) == CNT_FULL));

  // R12: a commit is a single-cycle pulse
  p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
#(
  parameter int AUX_W    = 8,
  parameter int BW_W     = 4,
  parameter int GAIN_W   = 9,
  parameter int PWR_W    = 7,
  parameter int CLAMP_W  = 10,
  parameter int GAIN_MAX = 319,
  localparam int RSV_LO  = 2 * BW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [SEL_W-1:0]   sel,
  input  logic [WORD_W-1:0]  word,
  output logic [AUX_W-1:0]   aux_code,
  output logic [BW_W-1:0]    bw_fast,
  output logic [BW_W-1:0]    bw_slow,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [PWR_W-1:0]   pwr_ctl,
  output logic [CLAMP_W-1:0] clamp_code,
  output logic               bw_err
);
  localparam logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] gain_req, gain_sat;
  logic              bw_rsv_set;

  assign gain_req   = word[GAIN_W-1:0];
  assign gain_sat   = (gain_req > GAIN_TOP) ? GAIN_TOP : gain_req;
  assign bw_rsv_set = |word[WORD_W-1:RSV_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_code   <= '0;
      bw_fast    <= '0;
      bw_slow    <= '0;
      gain_code  <= '0;
      pwr_ctl    <= '0;
      clamp_code <= '0;
      bw_err     <= 1'b0;
    end else if (stb) begin
      case (sel)
        SEL_AUX:   aux_code <= word[AUX_W-1:0];
        SEL_BW: begin
          if (bw_rsv_set) begin
            bw_err <= 1'b1;
          end else begin
            bw_fast <= word[BW_W-1:0];
            bw_slow <= word[2*BW_W-1:BW_W];
          end
        end
        SEL_GAIN:  gain_code  <= gain_sat;
        SEL_PWR:   pwr_ctl    <= word[PWR_W-1:0];
        SEL_CLAMP: clamp_code <= word[CLAMP_W-1:0];
        default: ;
      endcase
    end
  end

  // R5: stored gain never exceeds the top code
  p_gain_bound_r5: assert property (@(posedge clk) disable iff (rst)
    gain_code <= GAIN_TOP);

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    bw_err |=> bw_err);

  // R9: a reserved-bit bandwidth write keeps both codes and raises the flag
  p_rsv_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (stb && sel == SEL_BW && bw_rsv_set) |=> ($stable(bw_fast) && $stable(bw_slow) && bw_err));

  // R12: no output moves without a commit
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(aux_code) && $stable(bw_fast) && $stable(bw_slow) &&
              $stable(gain_code) && $stable(pwr_ctl) && $stable(clamp_code) && $stable(bw_err)));

  // R10: unused selectors touch nothing
  p_unused_sel_r10: assert property (@(posedge clk) disable iff (rst)
    (stb && sel > SEL_CLAMP) |=> ($stable(aux_code) && $stable(bw_fast) && $stable(bw_slow) &&
              $stable(gain_code) && $stable(pwr_ctl) && $stable(clamp_code) && $stable(bw_err)));
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
  import sctl_pkg::*;
#(
  parameter int AUX_W     = 8,
  parameter int BW_W      = 4,
  parameter int GAIN_W    = 9,
  parameter int PWR_W     = 7,
  parameter int CLAMP_W   = 10,
  parameter int GAIN_MAX  = 319,
  parameter int SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_en_n,
  output logic [AUX_W-1:0]   aux_code,
  output logic [BW_W-1:0]    bw_fast,
  output logic [BW_W-1:0]    bw_slow,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [PWR_W-1:0]   pwr_ctl,
  output logic [CLAMP_W-1:0] clamp_code,
  output logic               bw_err
);
  logic [2:0]        raw_in, sync_out;
  logic              stb;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] word;

  assign raw_in = {ser_en_n, ser_dat, ser_clk};

  sctl_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  sctl_frame #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sync_out[0]),
    .sdat_s (sync_out[1]),
    .en_n_s (sync_out[2]),
    .stb    (stb),
    .sel    (sel),
    .word   (word)
  );

  sctl_regs #(
    .AUX_W(AUX_W), .BW_W(BW_W), .GAIN_W(GAIN_W), .PWR_W(PWR_W),
    .CLAMP_W(CLAMP_W), .GAIN_MAX(GAIN_MAX)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .sel        (sel),
    .word       (word),
    .aux_code   (aux_code),
    .bw_fast    (bw_fast),
    .bw_slow    (bw_slow),
    .gain_code  (gain_code),
    .pwr_ctl    (pwr_ctl),
    .clamp_code (clamp_code),
    .bw_err     (bw_err)
  );
endmodule

// File: tb/sim_ser_ctl_bank.sv
`timescale 1ns/1ps
module sim_ser_ctl_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [7:0] aux_code;
  logic [3:0] bw_fast, bw_slow;
  logic [8:0] gain_code;
  logic [6:0] pwr_ctl;
  logic [9:0] clamp_code;
  logic       bw_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ser_ctl_bank u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .aux_code(aux_code), .bw_fast(bw_fast), .bw_slow(bw_slow), .gain_code(gain_code),
    .pwr_ctl(pwr_ctl), .clamp_code(clamp_code), .bw_err(bw_err)
  );

  // model state
  logic [7:0] m_aux;
  logic [3:0] m_fast, m_slow;
  logic [8:0] m_gain;
  logic [6:0] m_pwr;
  logic [9:0] m_clamp;
  logic       m_err;

  logic [42:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  function automatic logic [42:0] pack_exp();
    return {m_aux, m_fast, m_slow, m_gain, m_pwr, m_clamp, m_err};
  endfunction

  task automatic model_clear();
    m_aux = '0; m_fast = '0; m_slow = '0; m_gain = '0;
    m_pwr = '0; m_clamp = '0; m_err = 1'b0;
  endtask

  task automatic cmp(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  // monitor: pops expected snapshots and compares field by field
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [42:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "aux_code",   aux_code,   e[42:35]);
        cmp(t, "bw_fast",    bw_fast,    e[34:31]);
        cmp(t, "bw_slow",    bw_slow,    e[30:27]);
        cmp(t, "gain_code",  gain_code,  e[26:18]);
        cmp(t, "pwr_ctl",    pwr_ctl,    e[17:11]);
        cmp(t, "clamp_code", clamp_code, e[10:1]);
        cmp(t, "bw_err",     bw_err,     e[0]);
      end
    end
  end

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_raw(logic [15:0] bits, int n);
    wait_neg(3);
    ser_en_n = 1'b0;
    wait_neg(3);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_neg(5);
      ser_clk = 1'b1;
      wait_neg(5);
      ser_clk = 1'b0;
    end
    wait_neg(3);
    ser_en_n = 1'b1;
  endtask

  // driver: sends a word, updates the model, queues the expectation
  task automatic write(logic [2:0] sel, logic [9:0] word, int n, string tag);
    logic [15:0] bits;
    bits = 16'({sel, word});
    if (n == 12) bits = bits >> 1;
    if (n == 14) bits = bits << 1;
    send_raw(bits, n);
    if (n == 13) begin
      case (sel)
        3'd0: m_aux = word[7:0];
        3'd1: if (word[9:8] != 2'b00) m_err = 1'b1;
              else begin m_fast = word[3:0]; m_slow = word[7:4]; end
        3'd2: m_gain = (word[8:0] > 9'd319) ? 9'd319 : word[8:0];
        3'd3: m_pwr = word[6:0];
        3'd4: m_clamp = word;
        default: ;
      endcase
    end
    wait_neg(6); // R12 latency bound
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
    -> chk_ev;
    wait_neg(1);
  endtask

  task automatic push_now(string tag);
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
    -> chk_ev;
    wait_neg(1);
  endtask

  initial begin
    model_clear();
    wait_neg(4);
    rst = 1'b0;
    wait_neg(2);
    push_now("R11 reset");

    write(3'd0, 10'h0A5, 13, "R2 aux");
    write(3'd0, 10'h3FF, 13, "R2 aux upper bits");
    write(3'd1, 10'h03C, 13, "R3 bandwidth split");
    write(3'd2, 10'd200, 13, "R4 gain in range");
    write(3'd2, 10'd319, 13, "R4 gain top");
    write(3'd2, 10'd320, 13, "R5 gain clip");
    write(3'd2, 10'd511, 13, "R5 gain clip max");
    write(3'd2, 10'd0,   13, "R4 gain zero");
    write(3'd3, 10'h055, 13, "R6 power bits");
    write(3'd3, 10'h3AA, 13, "R6 power upper bits");
    write(3'd4, 10'h2B7, 13, "R7 clamp");
    write(3'd0, 10'h011, 12, "R8 short word");
    write(3'd4, 10'h001, 14, "R8 long word");
    write(3'd5, 10'h3FF, 13, "R10 sel5");
    write(3'd7, 10'h155, 13, "R10 sel7");
    write(3'd1, 10'h1F0, 13, "R9 reserved D8");
    write(3'd1, 10'h212, 13, "R9 reserved D9");
    write(3'd1, 10'h012, 13, "R9 sticky after valid");

    // R1: serial clocks while the enable is high are ignored
    for (int i = 0; i < 4; i++) begin
      ser_dat = 1'b1;
      wait_neg(5); ser_clk = 1'b1;
      wait_neg(5); ser_clk = 1'b0;
    end
    ser_dat = 1'b0;
    wait_neg(4);
    push_now("R1 idle clocks");
    write(3'd0, 10'h06C, 13, "R1 frame after idle clocks");

    // R11: reset in mid-operation
    wait_neg(1);
    rst = 1'b1;
    wait_neg(3);
    rst = 1'b0;
    model_clear();
    wait_neg(2);
    push_now("R11 reset after use");
    write(3'd2, 10'd77, 13, "R4 gain after reset");

    wait_neg(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule